// File: doc/BRIEF.md
# Multi-Mode Sample Buffer with Trigger Capture

This block holds up to 32 samples from a periodic source such as a sensor converter. It sits between the sample producer and the host read path. A 2-bit mode input selects one of four behaviours: off, circular overwrite (the newest samples win), fill-and-stop (the oldest samples win), and triggered capture. In triggered capture the buffer keeps a rolling window of pre-trigger history. It then records a fixed number of post-trigger samples and freezes.

The host pops samples from the head one at a time. It watches a sample count, an overflow flag and a watermark flag, and it acknowledges an interrupt-source bit with a status-read strobe. A flush request empties the buffer. The bench uses flush for events such as a data-rate change or a wake from standby. A change of mode between two active modes only takes effect after the mode has been set to off.

Top module: `sample_fifo_trig`

## Requirements
- R1: `count` reads 0 when the buffer is empty and 1 to 32 for stored samples. It never exceeds 32.
- R2: Mode 00 (off) empties the buffer and holds `count`, `ovf_flag`, `wm_flag` (with a non-zero watermark) and `int_src` at 0. Samples offered in this mode are dropped.
- R3: In mode 01 (circular), a sample arriving while 32 are stored evicts the oldest one, so the buffer holds the 32 most recent samples.
- R4: In mode 10 (fill), samples arriving while 32 are stored are refused and the stored contents stay as they are.
- R5: In mode 11 (capture), before the trigger the buffer keeps only the most recent `wmark` samples (the window is limited to 32). After the trigger it accepts exactly 32 minus that window of further samples and refuses every sample after that.
- R6: `wm_flag` is high exactly when `wmark` is non-zero and `count` is greater than or equal to `wmark`. A watermark of 0 keeps it low. Reaching the watermark never stops samples from being accepted.
- R7: `ovf_flag` is high when `count` is 32. In mode 11 it stays low before the trigger even when 32 samples are stored.
- R8: `int_src` sets in the cycle after an accepted sample leaves `ovf_flag` or `wm_flag` high. A `stat_rd` pulse clears it, and it stays clear until another sample is accepted while a flag is high.
- R9: `head_data` shows the oldest stored sample, or 0 when the buffer is empty. A `pop` removes that sample and lowers `count` by one. A `pop` on an empty buffer changes nothing.
- R10: A `flush` pulse empties the buffer and re-arms the trigger.
- R11: A request to move directly between two of the modes 01, 10 and 11 is ignored. A request to 00, or out of 00, takes effect at the next clock edge.
- R12: A sample and a pop in the same cycle, with the buffer neither empty nor full, both take effect and `count` stays the same.
- R13: A `trig` pulse counts only in mode 11 and only the first time. Later pulses do not restart the post-trigger allowance until the mode passes through 00 or a flush occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_req | input | 2 | Requested mode: 00 off, 01 circular, 10 fill, 11 capture |
| wmark | input | 6 | Watermark level and pre-trigger window |
| flush | input | 1 | Empty the buffer and re-arm the trigger |
| in_vld | input | 1 | A new sample is offered this cycle |
| in_data | input | 16 | Sample value |
| trig | input | 1 | Trigger event pulse |
| pop | input | 1 | Remove the head sample |
| stat_rd | input | 1 | Status read; clears the interrupt-source bit |
| head_data | output | 16 | Oldest stored sample, 0 when empty |
| count | output | 6 | Number of stored samples |
| ovf_flag | output | 1 | Buffer full (masked before the trigger in mode 11) |
| wm_flag | output | 1 | Count at or above the watermark |
| int_src | output | 1 | Sticky interrupt-source bit |

## Verification
The bench first targets the capture mode at its edges. A watermark of 32 leaves no post-trigger room, so a design that shows overflow before the trigger, or accepts a sample after it, is caught. A second trigger after some pops would let a design that restarts its post-trigger allowance collect 28 more samples instead of the 18 left. Circular overwrite is checked through the head value and the drain order, since an off-by-one eviction shows up as the wrong oldest sample. In fill mode an ignored direct mode change is checked through the head: a design that switched to circular would evict the head. The bench also covers a pop on an empty buffer, a sample and a pop in the same cycle, and the interrupt bit re-arming only on a new sample.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  typedef enum logic [1:0] {
    FM_OFF  = 2'b00,
    FM_CIRC = 2'b01,
    FM_FILL = 2'b10,
    FM_TRIG = 2'b11
  } fmode_e;

  // Next mode: leaving or entering off is allowed, active-to-active is not.
  function automatic fmode_e mode_step(fmode_e cur, logic [1:0] req);
    if (req == 2'b00 || cur == FM_OFF) return fmode_e'(req);
    return cur;
  endfunction

  // Pre-trigger window size, never larger than the storage.
  function automatic int wm_clamp(int wm, int depth);
    return (wm > depth) ? depth : wm;
  endfunction

  // Watermark comparison with zero meaning "disabled".
  function automatic logic wm_hit(int cnt, int wm);
    return (wm != 0) && (cnt >= wm);
  endfunction

endpackage

// File: rtl/sfifo_mode.sv
module sfifo_mode
  import sfifo_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_req,
  input  logic          flush,
  input  logic          trig,
  input  logic          push_ok,
  output fmode_e        mode_q,
  output logic          clr,
  output logic          trig_seen,
  output logic [CW-1:0] post_cnt
);

  fmode_e nxt_mode;

  always_comb begin
    nxt_mode = mode_step(mode_q, mode_req);
    clr      = flush || (nxt_mode == FM_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= FM_OFF;
      trig_seen <= 1'b0;
      post_cnt  <= '0;
    end else begin
      mode_q <= nxt_mode;
      if (clr) begin
        trig_seen <= 1'b0;
        post_cnt  <= '0;
      end else begin
        if (mode_q == FM_TRIG && trig) trig_seen <= 1'b1;
        if (trig_seen && push_ok) post_cnt <= post_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sfifo_admit.sv
module sfifo_admit
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = 6,
  parameter int WW    = 6
) (
  input  fmode_e        mode_q,
  input  logic          trig_seen,
  input  logic [CW-1:0] post_cnt,
  input  logic [CW-1:0] count,
  input  logic          in_vld,
  input  logic          pop,
  input  logic [WW-1:0] wmark,
  output logic          push_ok,
  output logic          pop_eff,
  output logic          drop
);

  int   wm_e;
  int   room;
  logic full;

  always_comb begin
    wm_e    = wm_clamp(int'(wmark), DEPTH);
    room    = DEPTH - wm_e;
    full    = (int'(count) == DEPTH);
    pop_eff = pop && (count != '0) && (mode_q != FM_OFF);
    push_ok = 1'b0;
    drop    = 1'b0;
    unique case (mode_q)
      FM_OFF: ;
      FM_CIRC: begin
        push_ok = in_vld;
        drop    = push_ok && !pop_eff && full;
      end
      FM_FILL: push_ok = in_vld && (!full || pop_eff);
      FM_TRIG: begin
        if (!trig_seen) begin
          push_ok = in_vld && (wm_e != 0);
          drop    = push_ok && !pop_eff && (int'(count) >= wm_e);
        end else begin
          push_ok = in_vld && (int'(post_cnt) < room) && (!full || pop_eff);
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  parameter int CW    = 6,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_ok,
  input  logic          pop_eff,
  input  logic          drop,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] count,
  output logic [DW-1:0] head
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          adv;

  assign adv  = pop_eff || drop;
  assign head = (count != '0) ? mem[rd_ptr] : '0;

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (adv)     rd_ptr <= rd_ptr + 1'b1;
      unique case ({push_ok, adv})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/sample_fifo_trig.sv
module sample_fifo_trig
  import sfifo_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  parameter int WW    = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   mode_req,
  input  logic [WW-1:0]                wmark,
  input  logic                         flush,
  input  logic                         in_vld,
  input  logic [DW-1:0]                in_data,
  input  logic                         trig,
  input  logic                         pop,
  input  logic                         stat_rd,
  output logic [DW-1:0]                head_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         ovf_flag,
  output logic                         wm_flag,
  output logic                         int_src
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  fmode_e        mode_q;
  logic          clr;
  logic          trig_seen;
  logic [CW-1:0] post_cnt;
  logic          push_ok;
  logic          pop_eff;
  logic          drop;
  logic          pushed_q;

  sfifo_mode #(.CW(CW)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_req  (mode_req),
    .flush     (flush),
    .trig      (trig),
    .push_ok   (push_ok),
    .mode_q    (mode_q),
    .clr       (clr),
    .trig_seen (trig_seen),
    .post_cnt  (post_cnt)
  );

  sfifo_admit #(.DEPTH(DEPTH), .CW(CW), .WW(WW)) u_admit (
    .mode_q    (mode_q),
    .trig_seen (trig_seen),
    .post_cnt  (post_cnt),
    .count     (count),
    .in_vld    (in_vld),
    .pop       (pop),
    .wmark     (wmark),
    .push_ok   (push_ok),
    .pop_eff   (pop_eff),
    .drop      (drop)
  );

  sfifo_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .push_ok (push_ok),
    .pop_eff (pop_eff),
    .drop    (drop),
    .wdata   (in_data),
    .count   (count),
    .head    (head_data)
  );

  always_comb begin
    ovf_flag = (int'(count) == DEPTH) && !(mode_q == FM_TRIG && !trig_seen);
    wm_flag  = wm_hit(int'(count), int'(wmark));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pushed_q <= 1'b0;
      int_src  <= 1'b0;
    end else if (clr) begin
      pushed_q <= 1'b0;
      int_src  <= 1'b0;
    end else begin
      pushed_q <= push_ok;
      if (pushed_q && (ovf_flag || wm_flag)) int_src <= 1'b1;
      else if (stat_rd)                      int_src <= 1'b0;
    end
  end

endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = 6,
  parameter int WW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_req,
  input logic          flush,
  input logic          in_vld,
  input logic          pop,
  input logic          stat_rd,
  input logic [WW-1:0] wmark,
  input logic [CW-1:0] count,
  input logic          ovf_flag,
  input logic          wm_flag,
  input logic          int_src,
  input logic [1:0]    mode_q,
  input logic          pushed_q
);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH); // R1

  AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00) |-> (count == '0 && !ovf_flag && !int_src)); // R2

  AST_FILL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b10 && int'(count) == DEPTH && !pop && !flush && mode_req != 2'b00)
      |=> (int'(count) == DEPTH)); // R4

  AST_TRIG_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b11 && ovf_flag && !pop && !flush && mode_req != 2'b00)
      |=> $stable(count)); // R5

  AST_WM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wmark == '0) |-> !wm_flag); // R6

  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> (int'(count) == DEPTH)); // R7

  AST_INT_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_src) |-> $past(pushed_q)); // R8

  AST_INT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (int_src && stat_rd && !pushed_q) |=> !int_src); // R8

  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count != '0 && !in_vld && !flush && mode_req != 2'b00 && mode_q != 2'b00)
      |=> (count == $past(count) - 1'b1)); // R9

  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && pop && count != '0 && int'(count) < DEPTH && mode_q == 2'b01
     && !flush && mode_req != 2'b00) |=> $stable(count)); // R12

endmodule

bind sample_fifo_trig sfifo_chk #(.DEPTH(DEPTH), .CW(CW), .WW(WW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_req (mode_req),
  .flush    (flush),
  .in_vld   (in_vld),
  .pop      (pop),
  .stat_rd  (stat_rd),
  .wmark    (wmark),
  .count    (count),
  .ovf_flag (ovf_flag),
  .wm_flag  (wm_flag),
  .int_src  (int_src),
  .mode_q   (mode_q),
  .pushed_q (pushed_q)
);

// File: tb/sample_fifo_trig_test.sv
module sample_fifo_trig_test;

  localparam int DW = 16;
  localparam int DEPTH = 32;
  localparam int WW = 6;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int VW = 31;
  localparam int NV = 11;

  // Vector: mode[30:29] vld[28] pop[27] trig[26] stat[25] din[24:17]
  //         cnt[16:11] ovf[10] wm[9] int[8] head[7:0]   (watermark = 2)
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 6'd0, 1'b0, 1'b0, 1'b0, 8'h00},
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 6'd1, 1'b0, 1'b0, 1'b0, 8'h11},
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h22, 6'd2, 1'b0, 1'b1, 1'b0, 8'h11},
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 6'd2, 1'b0, 1'b1, 1'b1, 8'h11},
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 6'd2, 1'b0, 1'b1, 1'b0, 8'h11},
    {2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 6'd1, 1'b0, 1'b0, 1'b0, 8'h22},
    {2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 8'h33, 6'd1, 1'b0, 1'b0, 1'b0, 8'h33},
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h44, 6'd2, 1'b0, 1'b1, 1'b0, 8'h33},
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 6'd2, 1'b0, 1'b1, 1'b1, 8'h33},
    {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 6'd2, 1'b0, 1'b1, 1'b1, 8'h33},
    {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 6'd0, 1'b0, 1'b0, 1'b0, 8'h00}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_req = 2'b00;
  logic [WW-1:0] wmark = '0;
  logic          flush = 1'b0;
  logic          in_vld = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          trig = 1'b0;
  logic          pop = 1'b0;
  logic          stat_rd = 1'b0;
  logic [DW-1:0] head_data;
  logic [CW-1:0] count;
  logic          ovf_flag;
  logic          wm_flag;
  logic          int_src;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  sample_fifo_trig #(.DW(DW), .DEPTH(DEPTH), .WW(WW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_req  (mode_req),
    .wmark     (wmark),
    .flush     (flush),
    .in_vld    (in_vld),
    .in_data   (in_data),
    .trig      (trig),
    .pop       (pop),
    .stat_rd   (stat_rd),
    .head_data (head_data),
    .count     (count),
    .ovf_flag  (ovf_flag),
    .wm_flag   (wm_flag),
    .int_src   (int_src)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive for one clock edge starting at a falling edge; returns at the next falling edge.
  task automatic cyc(input logic v, input int d, input logic p, input logic t,
                     input logic s, input logic f);
    in_vld  = v;
    in_data = DW'(d);
    pop     = p;
    trig    = t;
    stat_rd = s;
    flush   = f;
    @(negedge clk);
    in_vld  = 1'b0;
    pop     = 1'b0;
    trig    = 1'b0;
    stat_rd = 1'b0;
    flush   = 1'b0;
  endtask

  task automatic push(input int d);
    cyc(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic pop1();
    cyc(1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_req = m;
    cyc(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset count", int'(count), 0);
    check("R7 reset ovf", int'(ovf_flag), 0);
    check("R8 reset int", int'(int_src), 0);
    check("R9 reset head", int'(head_data), 0);

    // Table walk: circular basics, interrupt re-arm, push+pop pair (row 6, R12),
    // ignored direct mode change (row 9, R11), disable clears (row 10, R2).
    wmark = 6'd2;
    for (int i = 0; i < NV; i++) begin
      mode_req = VEC[i][30:29];
      cyc(VEC[i][28], int'(VEC[i][24:17]), VEC[i][27], VEC[i][26], VEC[i][25], 1'b0);
      check($sformatf("row%0d R1 count", i), int'(count), int'(VEC[i][16:11]));
      check($sformatf("row%0d R7 ovf", i), int'(ovf_flag), int'(VEC[i][10]));
      check($sformatf("row%0d R6 wm", i), int'(wm_flag), int'(VEC[i][9]));
      check($sformatf("row%0d R8 int", i), int'(int_src), int'(VEC[i][8]));
      check($sformatf("row%0d R9 head", i), int'(head_data), int'(VEC[i][7:0]));
    end

    // R3: circular overwrite keeps the newest 32 of 35
    set_mode(2'b01);
    for (int i = 0; i < 35; i++) push(100 + i);
    check("R3 circ count", int'(count), 32);
    check("R7 circ ovf", int'(ovf_flag), 1);
    check("R3 circ head", int'(head_data), 103);
    for (int k = 0; k < 32; k++) begin
      check("R9 drain order", int'(head_data), 103 + k);
      pop1();
    end
    check("R9 drained count", int'(count), 0);
    pop1();
    check("R9 empty pop count", int'(count), 0);
    check("R9 empty pop head", int'(head_data), 0);

    // R4: fill mode refuses when full; R11: direct change to circular ignored
    set_mode(2'b00);
    set_mode(2'b10);
    for (int i = 0; i < 40; i++) push(200 + i);
    check("R4 fill count", int'(count), 32);
    check("R4 fill head", int'(head_data), 200);
    check("R7 fill ovf", int'(ovf_flag), 1);
    mode_req = 2'b01;
    push(250);
    check("R11 ignored change head", int'(head_data), 200);
    check("R11 ignored change count", int'(count), 32);
    cyc(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R10 flush count", int'(count), 0);
    check("R10 flush ovf", int'(ovf_flag), 0);

    // R5/R13: capture with window 4
    set_mode(2'b00);
    wmark = 6'd4;
    set_mode(2'b11);
    for (int i = 0; i < 10; i++) push(300 + i);
    check("R5 pre-trigger count", int'(count), 4);
    check("R5 pre-trigger head", int'(head_data), 306);
    check("R7 pre-trigger ovf", int'(ovf_flag), 0);
    cyc(1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) push(400 + i);
    check("R5 post count", int'(count), 14);
    for (int i = 0; i < 10; i++) pop1();
    check("R9 capture head", int'(head_data), 406);
    cyc(1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) push(500 + i);
    check("R13 second trigger ignored count", int'(count), 22);
    check("R7 capture ovf", int'(ovf_flag), 0);
    pop1();
    push(600);
    check("R5 allowance spent", int'(count), 21);

    // R10: flush re-arms capture
    cyc(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) push(650 + i);
    check("R10 re-armed count", int'(count), 4);
    check("R10 re-armed head", int'(head_data), 652);

    // R7/R5: window 32 masks overflow until trigger, then freezes at once
    set_mode(2'b00);
    wmark = 6'd32;
    set_mode(2'b11);
    for (int i = 0; i < 40; i++) push(700 + i);
    check("R7 masked count", int'(count), 32);
    check("R7 masked ovf", int'(ovf_flag), 0);
    check("R5 window head", int'(head_data), 708);
    cyc(1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R7 ovf after trigger", int'(ovf_flag), 1);
    push(800);
    check("R5 frozen head", int'(head_data), 708);

    // R2: off mode drops samples; R6: watermark 0 disables flag
    set_mode(2'b00);
    push(900);
    check("R2 off ignores sample", int'(count), 0);
    wmark = 6'd0;
    set_mode(2'b01);
    for (int i = 0; i < 5; i++) push(910 + i);
    check("R6 zero watermark count", int'(count), 5);
    check("R6 zero watermark flag", int'(wm_flag), 0);
    check("R8 no flag no int", int'(int_src), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule